// File: doc/BRIEF.md
# Posted Write Ordering Buffer

This block sits on one direction of a bus bridge and absorbs memory writes from the originating side. A write is acknowledged there in the same cycle it is presented, as long as there is room. Its address, data, byte enables and a message-interrupt marker are stored in a first-in first-out queue. The queue is then emptied toward the destination side, one entry for each valid/ready handshake, in the order the writes arrived.

Reads going the same way must not pass writes that were posted earlier. A read request that finds any entry still queued gets a retry response, and a flushing flag stays raised until the queue has drained. The originator repeats the read, and the first attempt that finds the queue empty is accepted. Message-signalled interrupts are ordinary writes with a marker bit. They share the queue, so they can never arrive ahead of the data writes posted before them.

Top module: `pwb_top`

## Requirements
- R1: A write request (`req_valid`=1, `req_write`=1) made while the queue is not full gets `resp_accept`=1 and `resp_retry`=0 in the same cycle. The entry shows on the destination outputs from the next cycle.
- R2: A write request made while `full`=1 gets `resp_retry`=1 and `resp_accept`=0. It is not stored, so the queue holds exactly the entries it held before.
- R3: Entries leave on `dst_addr`/`dst_data`/`dst_be` in the same order they were accepted, with unchanged values.
- R4: While `dst_valid`=1 and `dst_ready`=0, the destination outputs hold steady. Each cycle with `dst_valid`=1 and `dst_ready`=1 removes exactly one entry.
- R5: A read request (`req_valid`=1, `req_write`=0) is accepted only when `empty`=1. If any entry is queued, it gets `resp_retry`=1 instead.
- R6: After a retried read, `flushing` is 1 from the next cycle for as long as entries remain. It returns to 0 in the same cycle that `empty` returns to 1.
- R7: `empty`=1 exactly when no entries are held, and `full`=1 exactly when DEPTH entries are held.
- R8: After reset, `empty`=1, `full`=0, `flushing`=0 and `dst_valid`=0.
- R9: The `req_msg` marker (1 = message interrupt) travels with its entry to `dst_msg`. A message write leaves only after every write accepted before it.
- R10: With `req_valid`=0, both `resp_accept` and `resp_retry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Originating-side request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_msg | input | 1 | Write is a message interrupt |
| req_addr | input | 32 | Request address |
| req_data | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| resp_accept | output | 1 | Request completed this cycle |
| resp_retry | output | 1 | Request must be repeated |
| dst_valid | output | 1 | Head entry available |
| dst_ready | input | 1 | Destination takes head entry |
| dst_addr | output | 32 | Head address |
| dst_data | output | 32 | Head data |
| dst_be | output | 4 | Head byte enables |
| dst_msg | output | 1 | Head is a message interrupt |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| flushing | output | 1 | Retried read waiting for drain |

## Verification
The hardest case to reach is a full queue that holds a message write behind data writes while a read and an extra write both get retried. The retried write must not disappear, and the drain must still deliver everything in order. The stimulus holds `dst_ready` low, posts DEPTH writes with a message write in the middle, and then issues the extra write and the read. It then drains while watching `flushing`, and expects it to fall exactly when the last entry leaves. After that, a repeat of the read must be accepted.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  parameter int unsigned PW_ADDR_W = 32;
  parameter int unsigned PW_DATA_W = 32;
  localparam int unsigned PW_BE_W = PW_DATA_W / 8;

  typedef struct packed {
    logic                 msg;
    logic [PW_BE_W-1:0]   be;
    logic [PW_DATA_W-1:0] data;
    logic [PW_ADDR_W-1:0] addr;
  } pw_entry_t;
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo
  import pwb_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  pw_entry_t push_entry,
  input  logic      pop,
  output pw_entry_t head,
  output logic      is_empty,
  output logic      is_full,
  output logic      last_leaving
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  pw_entry_t        store [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push && (cnt_q != CNT_FULL);
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr_q] <= push_entry;
  end

  assign head         = store[rd_ptr_q];
  assign is_empty     = (cnt_q == '0);
  assign is_full      = (cnt_q == CNT_FULL);
  assign last_leaving = do_pop && !do_push && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic q_empty,
  input  logic q_full,
  input  logic q_last_leaving,
  output logic push,
  output logic resp_accept,
  output logic resp_retry,
  output logic flushing
);
  logic wr_req, rd_req, rd_retry, wr_retry, rd_ok;
  logic flush_q, flush_d;

  always_comb begin
    wr_req   = req_valid && req_write;
    rd_req   = req_valid && !req_write;
    push     = wr_req && !q_full;
    wr_retry = wr_req && q_full;
    rd_ok    = rd_req && q_empty;
    rd_retry = rd_req && !q_empty;
    resp_accept = push || rd_ok;
    resp_retry  = wr_retry || rd_retry;
    flush_d  = (flush_q || rd_retry) && !q_last_leaving;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  assign flushing = flush_q;
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_msg,
  input  logic [PW_ADDR_W-1:0] req_addr,
  input  logic [PW_DATA_W-1:0] req_data,
  input  logic [PW_BE_W-1:0]   req_be,
  output logic                 resp_accept,
  output logic                 resp_retry,
  output logic                 dst_valid,
  input  logic                 dst_ready,
  output logic [PW_ADDR_W-1:0] dst_addr,
  output logic [PW_DATA_W-1:0] dst_data,
  output logic [PW_BE_W-1:0]   dst_be,
  output logic                 dst_msg,
  output logic                 empty,
  output logic                 full,
  output logic                 flushing
);
  pw_entry_t in_entry, head;
  logic      push, q_empty, q_full, q_last;

  assign in_entry = '{msg: req_msg, be: req_be, data: req_data, addr: req_addr};

  pwb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .q_empty(q_empty), .q_full(q_full), .q_last_leaving(q_last),
    .push(push), .resp_accept(resp_accept), .resp_retry(resp_retry),
    .flushing(flushing)
  );

  pwb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_entry(in_entry),
    .pop(dst_ready), .head(head), .is_empty(q_empty), .is_full(q_full),
    .last_leaving(q_last)
  );

  assign dst_valid = !q_empty;
  assign dst_addr  = head.addr;
  assign dst_data  = head.data;
  assign dst_be    = head.be;
  assign dst_msg   = head.msg;
  assign empty     = q_empty;
  assign full      = q_full;
endmodule

// File: rtl/pwb_checks.sv
module pwb_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        resp_accept,
  input logic        resp_retry,
  input logic        dst_valid,
  input logic        dst_ready,
  input logic [31:0] dst_addr,
  input logic [31:0] dst_data,
  input logic [3:0]  dst_be,
  input logic        dst_msg,
  input logic        empty,
  input logic        full,
  input logic        flushing
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && full) |-> (resp_retry && !resp_accept)); // R2
  AST_READ_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && resp_accept) |-> empty); // R5
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones({resp_accept, resp_retry}) == 1)); // R10
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(resp_accept || resp_retry)); // R10
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_addr) && $stable(dst_data)
                                   && $stable(dst_be) && $stable(dst_msg))); // R4
  AST_FLUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !empty); // R6
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R7
endmodule

bind pwb_top pwb_checks u_pwb_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .resp_accept(resp_accept), .resp_retry(resp_retry), .dst_valid(dst_valid),
  .dst_ready(dst_ready), .dst_addr(dst_addr), .dst_data(dst_data),
  .dst_be(dst_be), .dst_msg(dst_msg), .empty(empty), .full(full),
  .flushing(flushing)
);

// File: tb/pwb_top_test.sv
`timescale 1ns/1ps
module pwb_top_test;
  localparam int DEPTH = 8;

  logic clk, rst_n;
  logic req_valid, req_write, req_msg, dst_ready;
  logic [31:0] req_addr, req_data;
  logic [3:0]  req_be;
  logic resp_accept, resp_retry, dst_valid, dst_msg, empty, full, flushing;
  logic [31:0] dst_addr, dst_data;
  logic [3:0]  dst_be;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [68:0] exp_q[$];

  pwb_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_msg(req_msg), .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .resp_accept(resp_accept), .resp_retry(resp_retry), .dst_valid(dst_valid),
    .dst_ready(dst_ready), .dst_addr(dst_addr), .dst_data(dst_data),
    .dst_be(dst_be), .dst_msg(dst_msg), .empty(empty), .full(full),
    .flushing(flushing)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample responses, release after the edge
  task automatic do_req(input logic wr, input logic msg, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] be,
                        output logic acc, output logic rty);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_msg = msg;
    req_addr = a; req_data = d; req_be = be;
    #1;
    acc = resp_accept; rty = resp_retry;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (wr && acc) exp_q.push_back({msg, be, d, a});
  endtask

  // drains n entries, comparing each head against the bench's own record
  task automatic drain(input int n, input string req);
    @(negedge clk); #1;
    dst_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [68:0] e;
      e = exp_q.pop_front();
      chk(dst_valid && ({dst_msg, dst_be, dst_data, dst_addr} == e), req,
          {dst_msg, dst_be, dst_data, dst_addr}, e);
      @(negedge clk); #1;
    end
    dst_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk(empty && !full && !flushing && !dst_valid, "R8",
        {empty, full, flushing, dst_valid}, 4'b1000);
  endtask

  task automatic t_idle;
    @(negedge clk); #1;
    chk(!resp_accept && !resp_retry, "R10", {resp_accept, resp_retry}, 0);
  endtask

  task automatic t_single;
    logic acc, rty;
    do_req(1'b1, 1'b0, 32'h1000_0040, 32'hCAFE_0001, 4'b0011, acc, rty);
    chk(acc && !rty, "R1", {acc, rty}, 2'b10);
    @(negedge clk); #1;
    chk(dst_valid && !empty && dst_addr == 32'h1000_0040, "R1", {dst_valid, empty, dst_addr}, {2'b10, 32'h1000_0040});
    @(negedge clk); #1;
    chk(dst_data == 32'hCAFE_0001 && dst_be == 4'b0011, "R4", {dst_data, dst_be}, {32'hCAFE_0001, 4'b0011});
    drain(1, "R4");
    chk(empty && !dst_valid, "R4", {empty, dst_valid}, 2'b10);
  endtask

  task automatic t_read_empty;
    logic acc, rty;
    do_req(1'b0, 1'b0, 32'h2000_0000, 32'h0, 4'hF, acc, rty);
    chk(acc && !rty, "R5", {acc, rty}, 2'b10);
    chk(!flushing, "R6", flushing, 0);
  endtask

  task automatic t_full_flush;
    logic acc, rty;
    for (int i = 0; i < DEPTH; i++) begin
      do_req(1'b1, (i == 4), 32'h3000_0000 + 32'(i * 4), 32'hD000_0000 + 32'(i), 4'(i + 1), acc, rty);
      chk(acc && !rty, "R1", {acc, rty}, 2'b10);
    end
    chk(full && !empty, "R7", {full, empty}, 2'b10);
    do_req(1'b1, 1'b0, 32'hDEAD_0000, 32'hBAD0_BAD0, 4'hF, acc, rty);
    chk(rty && !acc, "R2", {acc, rty}, 2'b01);
    do_req(1'b0, 1'b0, 32'h2000_0004, 32'h0, 4'hF, acc, rty);
    chk(rty && !acc, "R5", {acc, rty}, 2'b01);
    chk(flushing, "R6", flushing, 1);
    // drain all but the last, order and message marker checked
    drain(DEPTH - 1, "R3 R9");
    chk(flushing && !empty, "R6", {flushing, empty}, 2'b10);
    drain(1, "R3");
    chk(empty && !flushing && !full, "R6", {empty, flushing, full}, 3'b100);
    chk(!dst_valid, "R2", dst_valid, 0);
    do_req(1'b0, 1'b0, 32'h2000_0004, 32'h0, 4'hF, acc, rty);
    chk(acc && !rty, "R5", {acc, rty}, 2'b10);
  endtask

  task automatic t_msg_order;
    logic acc, rty;
    do_req(1'b1, 1'b0, 32'h4000_0000, 32'h0000_00AA, 4'hF, acc, rty);
    do_req(1'b1, 1'b0, 32'h4000_0004, 32'h0000_00BB, 4'hC, acc, rty);
    do_req(1'b1, 1'b1, 32'hFEE0_0000, 32'h0000_0041, 4'h3, acc, rty);
    chk(acc, "R9", acc, 1);
    drain(3, "R9");
    chk(empty, "R7", empty, 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_msg = 1'b0;
    req_addr = '0; req_data = '0; req_be = '0; dst_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    t_reset();
    t_idle();
    t_single();
    t_read_empty();
    t_full_flush();
    t_msg_order();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule